// File: doc/BRIEF.md
# Prescaled Free-Running Timebase with Overflow and Periodic Tick

This block is the time reference for a small timer subsystem. A 16-bit counter runs freely from the bus clock. A prescaler sits in front of it and divides the bus clock by 1, 4, 8 or 16. When the counter rolls over from its all-ones value to zero, it raises an overflow flag. A second, independent divider chain counts bus cycles directly. It raises a tick flag at one of four power-of-two intervals, from 2^13 to 2^16 bus cycles.

Each flag has its own enable. The single interrupt request is active while any enabled flag is set. Software clears a flag by writing a one to that flag's bit position.

The prescale select is a one-time setup value. It is accepted only during the first 64 bus cycles after reset and is frozen after that. The tick rate select may be changed at any time. All ports are plain levels or single-cycle write strobes. There is no streaming data path, so there is no valid/ready handshake and no back-pressure.

Top module: `tick_timebase`

## Requirements
- R1: After reset the counter reads 0, both flags and the interrupt request are 0, the prescale code is 00 (divide by 1), the tick rate code is 00 and both enables are 0.
- R2: Prescale codes 00, 01, 10 and 11 advance the counter by one every 1, 4, 8 and 16 bus cycles respectively, so 64 bus cycles add 64, 16, 8 and 4 counts.
- R3: A prescale write is taken only on the first 64 clock edges after reset is released (edge 64 is accepted). A write on edge 65 or any later edge is ignored and the previous divide ratio stays in force.
- R4: The counter wraps from 0xFFFF to 0x0000, and the overflow flag (flag-write bit 7) is set on the same edge as the wrap.
- R5: With tick rate code n (0 to 3), the tick flag (flag-write bit 6) is set on every clock edge k after reset where k is a multiple of 2^(13+n). For code 00 the first such edge is 8192.
- R6: The tick divider counts bus cycles, so its timing does not depend on the prescale code.
- R7: A flag-write strobe clears each flag whose data bit (7 for overflow, 6 for tick) is 1 and leaves flags whose bit is 0 unchanged. If a set event and a clear fall on the same edge, the flag ends set.
- R8: The interrupt request equals (overflow flag AND mask bit 7) OR (tick flag AND mask bit 6). Mask bits are loaded by the mask-write strobe.
- R9: The tick rate code can be rewritten at any time after reset and takes effect from the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| presc_wr | input | 1 | Prescale code write strobe |
| presc_wdata | input | 2 | Prescale code |
| rate_wr | input | 1 | Tick rate code write strobe |
| rate_wdata | input | 2 | Tick rate code |
| flag_wr | input | 1 | Flag clear strobe |
| flag_wdata | input | 8 | Flag clear data (bit 7 overflow, bit 6 tick) |
| mask_wr | input | 1 | Enable write strobe |
| mask_wdata | input | 8 | Enable data (bit 7 overflow, bit 6 tick) |
| count | output | 16 | Free-running counter value |
| ovf_flag | output | 1 | Overflow flag |
| tick_flag | output | 1 | Periodic tick flag |
| irq | output | 1 | Interrupt request |

## Verification
Several properties are checked on every cycle by the assertions:
- the counter never moves by more than one step per cycle;
- the prescale code never changes once the setup window has closed;
- a wrap or a divider tick always sets its flag on the next edge;
- a clear without a coincident event always empties the flag;
- a flag only drops through a clear;
- the request stays low while no flag is set.

Some behaviour can only be shown by the bench's scenarios, because it needs long windows and exact edge numbers:
- the actual divide ratios over a 64-cycle window;
- the exact closing edge of the setup window;
- the tick intervals at edges 8192, 16384 and 32768;
- the full 65536-cycle wrap;
- the independence of the tick from the prescale code.

// File: rtl/tick_timebase_pkg.sv
package tick_timebase_pkg;
  localparam int REG_W    = 8;
  localparam int OVF_BIT  = 7;
  localparam int TICK_BIT = 6;
  localparam int SEL_W    = 2;

  typedef logic [SEL_W-1:0] sel_t;

  // Log2 of the prescale divisor for a given code: 0 -> 0, n -> n+1.
  function automatic int unsigned presc_shift(input sel_t code);
    return (code == '0) ? 0 : (int'(code) + 1);
  endfunction
endpackage

// File: rtl/tbase_presc_cnt.sv
module tbase_presc_cnt
  import tick_timebase_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int WINDOW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  sel_t             sel_wdata,
  output logic [CNT_W-1:0] count,
  output logic             wrap_evt
);
  localparam int PRE_W = 1 << SEL_W;
  localparam int WIN_W = $clog2(WINDOW + 1);

  logic [WIN_W-1:0] win_cnt;
  logic             win_open;
  sel_t             sel_q;
  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] pre_mask;
  logic             cnt_step;

  assign win_open = (win_cnt < WIN_W'(WINDOW));

  // Setup window: counts bus cycles since reset and saturates at its limit.
  always_ff @(posedge clk) begin
    if (!rst_n)        win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  sel_q <= '0;
    else if (sel_wr && win_open) sel_q <= sel_wdata;
  end

  always_comb begin
    pre_mask = PRE_W'((32'd1 << presc_shift(sel_q)) - 32'd1);
  end

  assign cnt_step = ((pre_cnt & pre_mask) == pre_mask);
  assign wrap_evt = cnt_step && (count == '1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_cnt <= '0;
      count   <= '0;
    end else begin
      pre_cnt <= pre_cnt + 1'b1;
      if (cnt_step) count <= count + 1'b1;
    end
  end

  // R3: once the window is closed the prescale code is frozen
  a_r3_sel_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !win_open |=> $stable(sel_q));

  // R2: the counter moves by at most one step per cycle
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (count == $past(count)) || (count == $past(count) + 1'b1));

  // R4: a wrap event lands the counter on zero
  a_r4_wrap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> (count == '0));
endmodule

// File: rtl/tbase_rt_div.sv
module tbase_rt_div
  import tick_timebase_pkg::*;
#(
  parameter int BASE_LOG2 = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rate_wr,
  input  sel_t rate_wdata,
  output logic tick_evt
);
  localparam int NSEL = 1 << SEL_W;
  localparam int RT_W = BASE_LOG2 + NSEL - 1;

  logic [RT_W-1:0] rt_cnt;
  sel_t            rate_q;
  logic [NSEL-1:0] tap;

  always_ff @(posedge clk) begin
    if (!rst_n)       rate_q <= '0;
    else if (rate_wr) rate_q <= rate_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rt_cnt <= '0;
    else        rt_cnt <= rt_cnt + 1'b1;
  end

  // One terminal-count tap per rate code: low (BASE_LOG2+i) bits all ones.
  for (genvar i = 0; i < NSEL; i++) begin : g_tap
    assign tap[i] = &rt_cnt[BASE_LOG2+i-1:0];
  end

  assign tick_evt = tap[rate_q];

  // R5: ticks are never on adjacent cycles
  a_r5_tick_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> !tick_evt);
endmodule

// File: rtl/tbase_flags.sv
module tbase_flags
  import tick_timebase_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap_evt,
  input  logic             tick_evt,
  input  logic             flag_wr,
  input  logic [REG_W-1:0] flag_wdata,
  input  logic             mask_wr,
  input  logic [REG_W-1:0] mask_wdata,
  output logic             ovf_flag,
  output logic             tick_flag,
  output logic             irq
);
  logic ovf_en;
  logic tick_en;
  logic ovf_clr;
  logic tick_clr;

  assign ovf_clr  = flag_wr && flag_wdata[OVF_BIT];
  assign tick_clr = flag_wr && flag_wdata[TICK_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_flag  <= 1'b0;
      tick_flag <= 1'b0;
    end else begin
      if (wrap_evt)     ovf_flag <= 1'b1;
      else if (ovf_clr) ovf_flag <= 1'b0;
      if (tick_evt)      tick_flag <= 1'b1;
      else if (tick_clr) tick_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ovf_en  <= 1'b0;
      tick_en <= 1'b0;
    end else if (mask_wr) begin
      ovf_en  <= mask_wdata[OVF_BIT];
      tick_en <= mask_wdata[TICK_BIT];
    end
  end

  assign irq = (ovf_flag && ovf_en) || (tick_flag && tick_en);

  // R4: the wrap sets the overflow flag
  a_r4_ovf_set: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_evt |=> ovf_flag);

  // R5: a divider tick sets the tick flag
  a_r5_tick_set: assert property (@(posedge clk) disable iff (!rst_n)
    tick_evt |=> tick_flag);

  // R7: a clear with no coincident event empties the flag
  a_r7_ovf_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_clr && !wrap_evt) |=> !ovf_flag);

  // R7: without a clear a set flag stays set
  a_r7_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  // R8: no flag, no request
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_flag && !tick_flag) |-> !irq);
endmodule

// File: rtl/tick_timebase.sv
module tick_timebase
  import tick_timebase_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int WINDOW    = 64,
  parameter int BASE_LOG2 = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             presc_wr,
  input  logic [1:0]       presc_wdata,
  input  logic             rate_wr,
  input  logic [1:0]       rate_wdata,
  input  logic             flag_wr,
  input  logic [7:0]       flag_wdata,
  input  logic             mask_wr,
  input  logic [7:0]       mask_wdata,
  output logic [CNT_W-1:0] count,
  output logic             ovf_flag,
  output logic             tick_flag,
  output logic             irq
);
  logic wrap_evt;
  logic tick_evt;

  tbase_presc_cnt #(.CNT_W(CNT_W), .WINDOW(WINDOW)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel_wr   (presc_wr),
    .sel_wdata(presc_wdata),
    .count    (count),
    .wrap_evt (wrap_evt)
  );

  tbase_rt_div #(.BASE_LOG2(BASE_LOG2)) u_rt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rate_wr   (rate_wr),
    .rate_wdata(rate_wdata),
    .tick_evt  (tick_evt)
  );

  tbase_flags u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .wrap_evt  (wrap_evt),
    .tick_evt  (tick_evt),
    .flag_wr   (flag_wr),
    .flag_wdata(flag_wdata),
    .mask_wr   (mask_wr),
    .mask_wdata(mask_wdata),
    .ovf_flag  (ovf_flag),
    .tick_flag (tick_flag),
    .irq       (irq)
  );

  // R1: the counter leaves reset at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (count == '0) && !ovf_flag && !tick_flag);
endmodule

// File: tb/test_tick_timebase.sv
module test_tick_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        presc_wr = 1'b0;
  logic [1:0]  presc_wdata = '0;
  logic        rate_wr = 1'b0;
  logic [1:0]  rate_wdata = '0;
  logic        flag_wr = 1'b0;
  logic [7:0]  flag_wdata = '0;
  logic        mask_wr = 1'b0;
  logic [7:0]  mask_wdata = '0;
  logic [15:0] count;
  logic        ovf_flag, tick_flag, irq;

  int n_checks = 0;
  int n_fail   = 0;
  int edges    = 0;
  int cyc      = 0;

  always #10 clk = ~clk;

  tick_timebase i_tick_timebase (
    .clk(clk), .rst_n(rst_n),
    .presc_wr(presc_wr), .presc_wdata(presc_wdata),
    .rate_wr(rate_wr), .rate_wdata(rate_wdata),
    .flag_wr(flag_wr), .flag_wdata(flag_wdata),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .count(count), .ovf_flag(ovf_flag), .tick_flag(tick_flag), .irq(irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 200000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected < 200000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    edges += n;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    presc_wr = 0; rate_wr = 0; flag_wr = 0; mask_wr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    edges = 0;
  endtask

  task automatic wr_presc(input logic [1:0] v);
    presc_wr = 1'b1; presc_wdata = v; step(1); presc_wr = 1'b0;
  endtask
  task automatic wr_rate(input logic [1:0] v);
    rate_wr = 1'b1; rate_wdata = v; step(1); rate_wr = 1'b0;
  endtask
  task automatic wr_flag(input logic [7:0] v);
    flag_wr = 1'b1; flag_wdata = v; step(1); flag_wr = 1'b0;
  endtask
  task automatic wr_mask(input logic [7:0] v);
    mask_wr = 1'b1; mask_wdata = v; step(1); mask_wr = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 count", int'(count), 0);
    chk("R1 ovf_flag", int'(ovf_flag), 0);
    chk("R1 tick_flag", int'(tick_flag), 0);
    chk("R1 irq", int'(irq), 0);
    step(10);
    chk("R1 default divide-by-1", int'(count), 10);
  endtask

  task automatic t_prescale();
    for (int code = 0; code < 4; code++) begin
      logic [15:0] c0;
      int sh;
      do_reset();
      wr_presc(2'(code));
      c0 = count;
      step(64);
      sh = (code == 0) ? 0 : code + 1;
      chk("R2 counts in 64 cycles", int'(16'(count - c0)), 64 >> sh);
    end
  endtask

  task automatic t_window();
    logic [15:0] c0;
    do_reset();
    step(63);
    wr_presc(2'd3);               // lands on edge 64
    c0 = count; step(64);
    chk("R3 write on edge 64 accepted", int'(16'(count - c0)), 4);
    do_reset();
    step(64);
    wr_presc(2'd3);               // lands on edge 65
    c0 = count; step(64);
    chk("R3 write on edge 65 ignored", int'(16'(count - c0)), 64);
    step(100);
    wr_presc(2'd1);
    c0 = count; step(64);
    chk("R3 late write ignored", int'(16'(count - c0)), 64);
  endtask

  task automatic t_tick();
    do_reset();
    wr_presc(2'd3);               // R6: slow prescale must not move the tick
    wr_mask(8'h40);
    step(8191 - edges);
    chk("R5 no tick before 8192", int'(tick_flag), 0);
    chk("R8 irq low", int'(irq), 0);
    step(1);
    chk("R5/R6 tick at edge 8192", int'(tick_flag), 1);
    chk("R8 irq from tick", int'(irq), 1);
    wr_flag(8'h80);
    chk("R7 other bit leaves tick", int'(tick_flag), 1);
    wr_flag(8'h00);
    chk("R7 zero write leaves tick", int'(tick_flag), 1);
    wr_flag(8'h40);
    chk("R7 clear tick", int'(tick_flag), 0);
    chk("R8 irq drops", int'(irq), 0);
    step(16383 - edges);
    wr_flag(8'h40);               // clear on edge 16384, same as set
    chk("R7 set wins over clear", int'(tick_flag), 1);
    wr_flag(8'h40);
    wr_rate(2'd1);                // R9: change rate mid-run
    step(32767 - edges);
    chk("R9 no tick before 32768", int'(tick_flag), 0);
    step(1);
    chk("R9/R5 tick at 32768 code 01", int'(tick_flag), 1);
  endtask

  task automatic t_overflow();
    do_reset();
    wr_rate(2'd3);
    wr_mask(8'h80);
    step(65535 - edges);
    chk("R4 count at 0xFFFF", int'(count), 65535);
    chk("R4 ovf not yet", int'(ovf_flag), 0);
    chk("R5 code 11 no early tick", int'(tick_flag), 0);
    chk("R8 irq low", int'(irq), 0);
    step(1);
    chk("R4 wrap to zero", int'(count), 0);
    chk("R4 ovf set on wrap", int'(ovf_flag), 1);
    chk("R5 tick at 65536", int'(tick_flag), 1);
    chk("R8 irq from ovf", int'(irq), 1);
    wr_mask(8'h00);
    chk("R8 masked irq", int'(irq), 0);
    chk("R8 flag kept when masked", int'(ovf_flag), 1);
    wr_flag(8'hC0);
    chk("R7 clear ovf", int'(ovf_flag), 0);
    chk("R7 clear tick", int'(tick_flag), 0);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_window();
    t_tick();
    t_overflow();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule